// File: doc/BRIEF.md
# Tag Fault Mode Dispatcher

This block takes a tag-check failure from the memory pipeline, together with the attributes of the failing access, and decides what happens next. It reads a two-bit policy field from the system control word of the translation regime in force. Depending on that field and on the direction of the access, it either emits a one-cycle synchronous abort with a syndrome and the faulting address, or records the failure in a sticky two-bit asynchronous status register kept for each exception level.

The asynchronous status registers can be read at all times. Software clears them by writing ones to chosen bits of one level's register. Routing the abort to a vector is left to the logic downstream.

Top module: `tag_fault_dispatch`

## Requirements
- R1: After reset every asynchronous status bit is 0 and `abort_o` is low.
- R2: The policy field is `ctrl_i[39:38]` when `el0_regime_i` is 1, and `ctrl_i[41:40]` otherwise. The other field has no effect.
- R3: Policy 1 produces an abort for a failure of either direction, and leaves the status registers unchanged.
- R4: Policy 2 records an asynchronous fault for a failure of either direction, and produces no abort.
- R5: Policy 3 produces an abort for a read (`wr_i`=0) and records an asynchronous fault for a write (`wr_i`=1).
- R6: An asynchronous fault sets status bit 1 when `two_ranges_i` is 1 and `addr_i[55]` is 1. In every other case it sets bit 0.
- R7: An abort carries `syndrome_o[5:0]`=6'h11, `syndrome_o[6]`=`wr_i` and `syndrome_o[7]`=`el_nz_i`. `fault_addr_o` equals `addr_i` of the failing access.
- R8: The fault is recorded in the slot of level 0 when `el0_regime_i` is 1, and in the slot of `regime_el_i` otherwise. Slot k occupies `async_st_o[2k+1:2k]`.
- R9: Status bits are sticky. A cycle with `clr_i`=1 clears the bits of slot `clr_el_i` that are set in `clr_mask_i`. When a set and a clear of the same bit fall in one cycle, the set wins.
- R10: A failure never arrives while the selected policy is 0 (checking disabled).
- R11: The abort is a registered pulse, high for exactly one cycle per failing access that leads to an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_i | input | 1 | Tag-check failure strobe |
| wr_i | input | 1 | Failing access was a write |
| el0_regime_i | input | 1 | Access ran in a level-0 regime |
| regime_el_i | input | 2 | Level that owns the regime when it is not a level-0 regime |
| el_nz_i | input | 1 | Current exception level is not zero |
| ctrl_i | input | 64 | System control word of the regime |
| two_ranges_i | input | 1 | Regime has two address ranges |
| addr_i | input | 64 | Faulting virtual address |
| clr_i | input | 1 | Software clear strobe |
| clr_el_i | input | 2 | Slot that the clear addresses |
| clr_mask_i | input | 2 | Write-one-to-clear bit mask |
| abort_o | output | 1 | Synchronous abort pulse |
| syndrome_o | output | 8 | Abort syndrome |
| fault_addr_o | output | 64 | Abort virtual address |
| async_st_o | output | 8 | Asynchronous status, two bits per level |

## Verification
Every result lands one clock edge after its stimulus. The abort pulse, syndrome and address are registered, and the status bits update at the same edge that samples the failure or the clear. The bench applies inputs on the falling edge and compares all outputs on the next falling edge, before it applies the next stimulus. This lets failures arrive back to back and still be checked one by one. Clears that collide with sets are placed in the same cycle on purpose, so that the set-wins rule is checked.

// File: rtl/tag_fault_dispatch.sv
module tag_fault_dispatch #(
  parameter int ADDR_W = 64,
  parameter int CTRL_W = 64,
  parameter int NUM_EL = 4,
  parameter int EL_W   = $clog2(NUM_EL),
  parameter int SEL_BIT = 55,
  parameter int EL0_LO = 38,
  parameter int ELX_LO = 40,
  parameter logic [5:0] FSC = 6'h11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fail_i,
  input  logic                wr_i,
  input  logic                el0_regime_i,
  input  logic [EL_W-1:0]     regime_el_i,
  input  logic                el_nz_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic                two_ranges_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                clr_i,
  input  logic [EL_W-1:0]     clr_el_i,
  input  logic [1:0]          clr_mask_i,
  output logic                abort_o,
  output logic [7:0]          syndrome_o,
  output logic [ADDR_W-1:0]   fault_addr_o,
  output logic [2*NUM_EL-1:0] async_st_o
);

  logic [1:0]      mode;
  logic            go_sync, go_async;
  logic [1:0]      set_bits;
  logic [EL_W-1:0] slot;

  assign mode     = el0_regime_i ? ctrl_i[EL0_LO +: 2] : ctrl_i[ELX_LO +: 2];
  assign go_sync  = fail_i && ((mode == 2'd1) || (mode == 2'd3 && !wr_i));
  assign go_async = fail_i && ((mode == 2'd2) || (mode == 2'd3 && wr_i));
  assign set_bits = (two_ranges_i && addr_i[SEL_BIT]) ? 2'b10 : 2'b01;
  assign slot     = el0_regime_i ? '0 : regime_el_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_o      <= 1'b0;
      syndrome_o   <= '0;
      fault_addr_o <= '0;
    end else begin
      abort_o <= go_sync;
      if (go_sync) begin
        syndrome_o   <= {el_nz_i, wr_i, FSC};
        fault_addr_o <= addr_i;
      end
    end
  end

  for (genvar k = 0; k < NUM_EL; k++) begin : g_slot
    logic [1:0] clr_k, set_k;
    assign clr_k = (clr_i && clr_el_i == EL_W'(k)) ? clr_mask_i : 2'b00;
    assign set_k = (go_async && slot == EL_W'(k)) ? set_bits : 2'b00;
    always_ff @(posedge clk) begin
      if (!rst_n) async_st_o[2*k +: 2] <= 2'b00;
      else        async_st_o[2*k +: 2] <= (async_st_o[2*k +: 2] & ~clr_k) | set_k;
    end
  end

endmodule

module tag_fault_dispatch_chk #(
  parameter int ADDR_W = 64,
  parameter int CTRL_W = 64,
  parameter int NUM_EL = 4,
  parameter int EL_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fail_i,
  input logic                wr_i,
  input logic                el0_regime_i,
  input logic [CTRL_W-1:0]   ctrl_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                el_nz_i,
  input logic                clr_i,
  input logic                abort_o,
  input logic [7:0]          syndrome_o,
  input logic [ADDR_W-1:0]   fault_addr_o,
  input logic [2*NUM_EL-1:0] async_st_o
);
  logic [1:0] pol;
  assign pol = el0_regime_i ? ctrl_i[39:38] : ctrl_i[41:40];

  p_no_mode0_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |-> pol != 2'd0);

  p_abort_needs_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(fail_i));

  p_async_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && pol == 2'd2) |=> !abort_o);

  p_sync_no_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && pol == 2'd1 && !clr_i) |=> $stable(async_st_o));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((async_st_o & $past(async_st_o)) == $past(async_st_o)));

  p_syndrome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (syndrome_o == {$past(el_nz_i), $past(wr_i), 6'h11}));

  p_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> fault_addr_o == $past(addr_i));
endmodule

bind tag_fault_dispatch tag_fault_dispatch_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .NUM_EL(NUM_EL), .EL_W(EL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fail_i(fail_i), .wr_i(wr_i),
  .el0_regime_i(el0_regime_i), .ctrl_i(ctrl_i), .addr_i(addr_i),
  .el_nz_i(el_nz_i), .clr_i(clr_i), .abort_o(abort_o),
  .syndrome_o(syndrome_o), .fault_addr_o(fault_addr_o),
  .async_st_o(async_st_o)
);

// File: tb/tag_fault_dispatch_tb.sv
module tag_fault_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fail_i = 0, wr_i = 0, el0_regime_i = 0, el_nz_i = 0;
  logic [1:0]  regime_el_i = 0, clr_el_i = 0, clr_mask_i = 0;
  logic [63:0] ctrl_i = 0, addr_i = 0;
  logic        two_ranges_i = 0, clr_i = 0;
  logic        abort_o;
  logic [7:0]  syndrome_o;
  logic [63:0] fault_addr_o;
  logic [7:0]  async_st_o;

  int tests = 0, fails = 0;
  logic [7:0] exp_st = 8'h00;

  tag_fault_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .fail_i(fail_i), .wr_i(wr_i),
    .el0_regime_i(el0_regime_i), .regime_el_i(regime_el_i), .el_nz_i(el_nz_i),
    .ctrl_i(ctrl_i), .two_ranges_i(two_ranges_i), .addr_i(addr_i),
    .clr_i(clr_i), .clr_el_i(clr_el_i), .clr_mask_i(clr_mask_i),
    .abort_o(abort_o), .syndrome_o(syndrome_o), .fault_addr_o(fault_addr_o),
    .async_st_o(async_st_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pol_of(input logic el0, input logic [63:0] c);
    return el0 ? c[39:38] : c[41:40];
  endfunction

  function automatic logic is_sync(input logic [1:0] m, input logic w);
    return (m == 2'd1) || (m == 2'd3 && !w);
  endfunction

  // drive one cycle at negedge, check at next negedge
  task automatic step(input logic f, input logic w, input logic el0, input logic [1:0] rel,
                      input logic nz, input logic [63:0] c, input logic tr,
                      input logic [63:0] a, input logic cl, input logic [1:0] cel,
                      input logic [1:0] cm, input string req);
    logic [1:0] m, sb, sl;
    logic sync, asyn;
    fail_i = f; wr_i = w; el0_regime_i = el0; regime_el_i = rel; el_nz_i = nz;
    ctrl_i = c; two_ranges_i = tr; addr_i = a; clr_i = cl; clr_el_i = cel; clr_mask_i = cm;
    m    = pol_of(el0, c);
    sync = f && is_sync(m, w);
    asyn = f && !is_sync(m, w);
    sb   = (tr && a[55]) ? 2'b10 : 2'b01;
    sl   = el0 ? 2'd0 : rel;
    if (cl) exp_st[2*cel +: 2] = exp_st[2*cel +: 2] & ~cm;
    if (asyn) exp_st[2*sl +: 2] = exp_st[2*sl +: 2] | sb;
    @(negedge clk);
    fail_i = 0; clr_i = 0;
    chk({req, " R11 abort"}, 64'(abort_o), 64'(sync));
    chk({req, " R8 R6 R9 status"}, 64'(async_st_o), 64'(exp_st));
    if (sync) begin
      chk({req, " R7 syndrome"}, 64'(syndrome_o), 64'({nz, w, 6'h11}));
      chk({req, " R7 addr"}, fault_addr_o, a);
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 status", 64'(async_st_o), 0);
    chk("R1 abort", 64'(abort_o), 0);

    // R2: EL0 field 1 (sync), other field 2
    step(1, 1, 1, 0, 0, 64'h0000_0200_0000_0000 | 64'h40_0000_0000, 0, 64'h1234, 0, 0, 0, "R2 el0 field");
    // R2: non-EL0 field 2 (async), EL0 field 1
    step(1, 0, 0, 2, 1, 64'h0000_0200_0000_0000 | 64'h40_0000_0000, 1, 64'h0080_0000_0000_0000, 0, 0, 0, "R2 elx field");
    // R3 policy 1 write
    step(1, 1, 0, 1, 1, 64'h100_0000_0000, 0, 64'hdead_beef, 0, 0, 0, "R3 pol1 write");
    // R5 mixed read then write
    step(1, 0, 0, 3, 1, 64'h300_0000_0000, 0, 64'h55, 0, 0, 0, "R5 mixed read");
    step(1, 1, 0, 3, 0, 64'h300_0000_0000, 1, 64'h0080_0000_0000_0010, 0, 0, 0, "R5 mixed write");
    // R6 two ranges with bit55 clear, and bit55 set with one range
    step(1, 1, 1, 0, 0, 64'hC0_0000_0000, 1, 64'h0, 0, 0, 0, "R6 bit55 zero");
    step(1, 1, 1, 0, 0, 64'hC0_0000_0000, 0, 64'h0080_0000_0000_0000, 0, 0, 0, "R6 one range");
    // R9 set and clear same bit same cycle: set wins
    step(1, 0, 1, 0, 0, 64'h80_0000_0000, 0, 64'h0, 1, 0, 2'b11, "R9 set wins");
    // R9 clear slot 2 bit 1 only
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 2'b10, "R9 clear");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 sticky idle");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] c, a;
      logic el0, w;
      logic [1:0] m;
      c   = {$urandom, $urandom};
      a   = {$urandom, $urandom};
      el0 = 1'($urandom);
      w   = 1'($urandom);
      m   = 2'($urandom_range(1, 3));
      if (el0) c[39:38] = m; else c[41:40] = m;
      step(1'($urandom_range(0, 3) != 0), w, el0, 2'($urandom_range(1, 3)), 1'($urandom),
           c, 1'($urandom), a, 1'($urandom_range(0, 3) == 0), 2'($urandom), 2'($urandom),
           "R3 R4 R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule